// File: doc/BRIEF.md
# Stereo PDM Interface Receiver

This block sits on the host side of a pair of 1-bit pulse-density-modulated audio sources that share one clock wire and one tri-stated data wire. It divides the system clock down to a bit clock for both sources. It samples the shared wire twice per bit-clock period, each time late in a half-period, and sorts the samples into a left bit stream and a right bit stream. Each stream has a one-cycle valid strobe.

The left source drives the wire while the bit clock is low, and the right source drives it while the clock is high. The receiver therefore takes the left sample in the last system cycle before the bit clock rises, and the right sample in the last system cycle before it falls. This leaves each source the whole half-period to settle, and the capture happens before the other source starts driving. In a mono setup one source holds the wire for the full period, and the sample that belongs to its channel still lands on the correct stream.

A per-channel ones counter gives a coarse level reading. It counts the 1 bits over a window of 2^k bits and reports the count once the window closes. A 1 bit stands for a positive excursion. A count of half the window means zero signal, a full window means positive full scale, and zero means negative full scale. A run input stops the bit clock at a period boundary, which lets the attached sources go into their low-power sleep.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While reset is asserted and after its release, the bit clock is low and every valid strobe is low. Both level outputs are zero until the first window completes.
- R2: While the clock is running, one bit-clock period lasts max(div_ratio,4) system cycles. Within a period a low phase comes first, and the high phase that follows lasts floor(max(div_ratio,4)/2) cycles.
- R3: A new value on div_ratio takes effect only at a period boundary, meaning at a falling edge of the bit clock. The period in progress keeps its old length.
- R4: left_valid pulses for exactly one cycle, in the cycle in which the bit clock output goes high. left_bit then holds the value the data line had in the preceding system cycle, and keeps it until the next left capture.
- R5: right_valid pulses for exactly one cycle, in the cycle in which the bit clock output goes low. right_bit then holds the value the data line had in the preceding system cycle.
- R6: When bclk_run goes low, the current period, including its full high phase, completes. After that the bit clock stays low and no strobe fires. When bclk_run returns high, the first rising edge appears in the sixth cycle after the input change for a ratio of 8: one cycle to start the clock, then the low phase of 4 cycles.
- R7: Each channel's level output equals the number of 1 bits among 2^k consecutive captured bits of that channel. level_valid pulses for one cycle, one cycle after the strobe of the window's last bit.
- R8: The window exponent k is taken from win_log2 at the first bit of each window and held until that window ends. Values above MAX_K are treated as MAX_K.
- R9: A div_ratio below 4 (including 0) behaves exactly like 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ratio | input | DIV_W | System cycles per bit-clock period (minimum 4) |
| bclk_run | input | 1 | Bit clock runs while high; stops at a period boundary when low |
| win_log2 | input | KW | Level window exponent k (window of 2^k bits) |
| pdm_line | input | 1 | Shared data wire from both sources |
| pdm_bclk | output | 1 | Bit clock driven to the sources |
| left_bit | output | 1 | Last captured left sample |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_bit | output | 1 | Last captured right sample |
| right_valid | output | 1 | One-cycle strobe for a new right sample |
| left_level | output | MAX_K+1 | Ones count of the last completed left window |
| left_level_valid | output | 1 | One-cycle strobe for a new left level |
| right_level | output | MAX_K+1 | Ones count of the last completed right window |
| right_level_valid | output | 1 | One-cycle strobe for a new right level |

## Verification
Both strobes are due in the same cycle as the bit-clock edge that matches them. The bench reads them at the falling system edge of that cycle and compares the bit against the value its own source model put on the wire for that half-period. A level reading is due exactly one cycle after the last strobe of its window. The bench keeps a pending flag per channel and flags a reading that comes late or early. Period and high-phase lengths are measured from edge to edge in system cycles and checked against the ratio in force. Around ratio changes, and when restarting after a stop, the bench waits for the boundary that R3 and R6 define before it switches its expected values. The first rising edge after a restart is counted from the input change.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

    // Smallest divider ratio the clock generator accepts.
    localparam int unsigned PDM_MIN_RATIO = 4;

    // One captured sample with its strobe.
    typedef struct packed {
        logic valid;
        logic data;
    } pdm_bit_t;

    localparam int unsigned PDM_LEFT  = 0;
    localparam int unsigned PDM_RIGHT = 1;

endpackage

// File: rtl/pdm_rx_clkgen.sv
module pdm_rx_clkgen
    import pdm_rx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ratio_i,
    input  logic             run_i,
    output logic             bclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    localparam logic [DIV_W-1:0] MIN_R = DIV_W'(PDM_MIN_RATIO);

    typedef struct packed {
        logic             running;
        logic             bclk;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
    } gen_t;

    gen_t             s_q, s_d;
    logic [DIV_W-1:0] eff_ratio;
    logic [DIV_W-1:0] low_len;

    always_comb begin
        eff_ratio = (ratio_i < MIN_R) ? MIN_R : ratio_i;
        s_d       = s_q;
        if (!s_q.running) begin
            if (run_i) begin
                s_d.running = 1'b1;
                s_d.cnt     = '0;
                s_d.ratio   = eff_ratio;
            end
        end else if (s_q.cnt == s_q.ratio - 1'b1) begin
            // Period boundary: the only place ratio or run state may change.
            s_d.cnt = '0;
            if (run_i) begin
                s_d.ratio = eff_ratio;
            end else begin
                s_d.running = 1'b0;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        low_len  = s_d.ratio - (s_d.ratio >> 1);
        s_d.bclk = s_d.running && (s_d.cnt >= low_len);
        rise_o   = !s_q.bclk && s_d.bclk;
        fall_o   = s_q.bclk && !s_d.bclk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bclk_o = s_q.bclk;

    // R9: an active divider never runs below the minimum ratio.
    a_r9_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.running |-> (s_q.ratio >= MIN_R));

    // R3: the ratio only changes when the count has wrapped.
    a_r3_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.running && $past(s_q.running) && (s_q.cnt != '0)) |-> $stable(s_q.ratio));

    // R6: stopping happens only at the end of a full period.
    a_r6_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.running) |-> ($past(s_q.cnt) == $past(s_q.ratio) - 1'b1));

endmodule

// File: rtl/pdm_rx_capture.sv
module pdm_rx_capture
    import pdm_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_i,
    input  logic     rise_i,
    input  logic     fall_i,
    output pdm_bit_t left_o,
    output pdm_bit_t right_o
);

    typedef struct packed {
        pdm_bit_t left;
        pdm_bit_t right;
    } cap_t;

    cap_t s_q, s_d;

    always_comb begin
        s_d             = s_q;
        // Left source owns the low half: sample just before the rise.
        s_d.left.valid  = rise_i;
        s_d.left.data   = rise_i ? line_i : s_q.left.data;
        // Right source owns the high half: sample just before the fall.
        s_d.right.valid = fall_i;
        s_d.right.data  = fall_i ? line_i : s_q.right.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign left_o  = s_q.left;
    assign right_o = s_q.right;

    // R4/R5: the two channel strobes never coincide.
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.left.valid && s_q.right.valid));

endmodule

// File: rtl/pdm_rx_density.sv
module pdm_rx_density
    import pdm_rx_pkg::*;
#(
    parameter int MAX_K = 6,
    parameter int KW    = $clog2(MAX_K + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  pdm_bit_t       bit_i,
    input  logic [KW-1:0]  win_i,
    output logic [MAX_K:0] level_o,
    output logic           level_valid_o
);

    localparam int CW = MAX_K + 1;
    localparam logic [KW-1:0] K_TOP = KW'(MAX_K);

    typedef struct packed {
        logic [KW-1:0] k;
        logic [CW-1:0] nbits;
        logic [CW-1:0] ones;
        logic [CW-1:0] level;
        logic          lvalid;
    } dens_t;

    dens_t         s_q, s_d;
    logic [KW-1:0] k_use;
    logic [CW-1:0] ones_next;

    always_comb begin
        s_d        = s_q;
        s_d.lvalid = 1'b0;
        k_use      = (s_q.nbits == '0) ? win_i : s_q.k;
        if (k_use > K_TOP) begin
            k_use = K_TOP;
        end
        ones_next = s_q.ones + CW'(bit_i.data);
        if (bit_i.valid) begin
            s_d.k = k_use;
            if (s_q.nbits == (CW'(1) << k_use) - 1'b1) begin
                s_d.level  = ones_next;
                s_d.lvalid = 1'b1;
                s_d.nbits  = '0;
                s_d.ones   = '0;
            end else begin
                s_d.nbits = s_q.nbits + 1'b1;
                s_d.ones  = ones_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o       = s_q.level;
    assign level_valid_o = s_q.lvalid;

    // R7: a reported count never exceeds the window it came from.
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lvalid |-> (s_q.level <= (CW'(1) << s_q.k)));

    // R7: a report always follows a sample strobe by one cycle.
    a_r7_report_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lvalid |-> $past(bit_i.valid));

    // R8: the window exponent stays put while a window is open.
    a_r8_k_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.nbits != '0) && !bit_i.valid) |=> $stable(s_q.k));

endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
    import pdm_rx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int MAX_K = 6,
    localparam int KW   = $clog2(MAX_K + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             bclk_run,
    input  logic [KW-1:0]    win_log2,
    input  logic             pdm_line,
    output logic             pdm_bclk,
    output logic             left_bit,
    output logic             left_valid,
    output logic             right_bit,
    output logic             right_valid,
    output logic [MAX_K:0]   left_level,
    output logic             left_level_valid,
    output logic [MAX_K:0]   right_level,
    output logic             right_level_valid
);

    logic           rise_next;
    logic           fall_next;
    pdm_bit_t       chan [2];
    logic [MAX_K:0] lvl  [2];
    logic           lvl_v[2];

    pdm_rx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .ratio_i(div_ratio),
        .run_i  (bclk_run),
        .bclk_o (pdm_bclk),
        .rise_o (rise_next),
        .fall_o (fall_next)
    );

    pdm_rx_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (pdm_line),
        .rise_i (rise_next),
        .fall_i (fall_next),
        .left_o (chan[PDM_LEFT]),
        .right_o(chan[PDM_RIGHT])
    );

    for (genvar g = 0; g < 2; g++) begin : g_level
        pdm_rx_density #(.MAX_K(MAX_K), .KW(KW)) u_density (
            .clk          (clk),
            .rst_n        (rst_n),
            .bit_i        (chan[g]),
            .win_i        (win_log2),
            .level_o      (lvl[g]),
            .level_valid_o(lvl_v[g])
        );
    end

    assign left_bit          = chan[PDM_LEFT].data;
    assign left_valid        = chan[PDM_LEFT].valid;
    assign right_bit         = chan[PDM_RIGHT].data;
    assign right_valid       = chan[PDM_RIGHT].valid;
    assign left_level        = lvl[PDM_LEFT];
    assign left_level_valid  = lvl_v[PDM_LEFT];
    assign right_level       = lvl[PDM_RIGHT];
    assign right_level_valid = lvl_v[PDM_RIGHT];

    // R4: a left sample appears together with the rising bit clock.
    a_r4_left_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |-> $rose(pdm_bclk));

    // R5: a right sample appears together with the falling bit clock.
    a_r5_right_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |-> $fell(pdm_bclk));

    // R4: the left strobe lasts a single cycle.
    a_r4_left_single: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |=> !left_valid);

    // R5: the right strobe lasts a single cycle.
    a_r5_right_single: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |=> !right_valid);

endmodule

// File: tb/pdm_stereo_rx_test.sv
module pdm_stereo_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int MAX_K      = 6;
    localparam int KW         = $clog2(MAX_K + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_ratio = 8'd6;
    logic             bclk_run = 1'b0;
    logic [KW-1:0]    win_log2 = '0;
    logic             pdm_line;
    logic             pdm_bclk;
    logic             left_bit, left_valid, right_bit, right_valid;
    logic [MAX_K:0]   left_level, right_level;
    logic             left_level_valid, right_level_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdm_stereo_rx #(.DIV_W(DIV_W), .MAX_K(MAX_K)) uut (
        .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .bclk_run(bclk_run),
        .win_log2(win_log2), .pdm_line(pdm_line), .pdm_bclk(pdm_bclk),
        .left_bit(left_bit), .left_valid(left_valid),
        .right_bit(right_bit), .right_valid(right_valid),
        .left_level(left_level), .left_level_valid(left_level_valid),
        .right_level(right_level), .right_level_valid(right_level_valid)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pat(input int m, input int idx, input int ch);
        case (m)
            0:       return idx[0];
            1:       return 1'b1;
            2:       return 1'b0;
            default: return (ch == 0) ? ((idx % 3) == 0) : (((idx * 5) % 7) < 3);
        endcase
    endfunction

    // Two-source model: left drives during low half, right during high half.
    int   mode = 0;
    int   lidx = 0, ridx = 0;
    logic lcur, rcur = 1'b0;
    initial begin
        lcur     = pat(0, 0, 0);
        pdm_line = lcur;
    end
    always @(pdm_bclk) begin
        #1;
        if (pdm_bclk) begin
            ridx++;
            rcur     = pat(mode, ridx, 1);
            pdm_line = rcur;
        end else begin
            lidx++;
            lcur     = pat(mode, lidx, 0);
            pdm_line = lcur;
        end
    end

    // Monitor state
    int   cyc = 0, rise_t = 0, fall_t = 0, fall_count = 0;
    int   last_per = 0, last_hi = 0;
    logic have_prev = 1'b0, prev_bclk = 1'b0, mon_en = 1'b0, mon_on = 1'b0;
    int   exp_ratio = 6;
    int   dn[2], dones[2], dk[2], dexp[2];
    logic dpend[2];
    initial begin
        for (int c = 0; c < 2; c++) begin
            dn[c] = 0; dones[c] = 0; dk[c] = 0; dexp[c] = 0; dpend[c] = 1'b0;
        end
    end

    function automatic int kclamp(input int k);
        return (k > MAX_K) ? MAX_K : k;
    endfunction

    // R7/R8 model: k taken at a window's first bit, count reported one cycle after last bit.
    task automatic dens_level(input int ch, input logic lv, input int lvl);
        string tag;
        tag = (dk[ch] != kclamp(int'(win_log2))) ? "R8" : "R7";
        if (lv) begin
            chk(dpend[ch] && (lvl == dexp[ch]), tag, lvl, dexp[ch]);
        end else if (dpend[ch]) begin
            chk(1'b0, "R7 level late", 0, dexp[ch]);
        end
        dpend[ch] = 1'b0;
    endtask

    task automatic dens_bit(input int ch, input logic b);
        if (dn[ch] == 0) dk[ch] = kclamp(int'(win_log2));
        dones[ch] += int'(b);
        dn[ch]++;
        if (dn[ch] == (1 << dk[ch])) begin
            dexp[ch]  = dones[ch];
            dpend[ch] = 1'b1;
            dn[ch]    = 0;
            dones[ch] = 0;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            cyc++;
            dens_level(0, left_level_valid, int'(left_level));
            dens_level(1, right_level_valid, int'(right_level));
            if (left_valid) begin
                chk(left_bit == lcur, "R4 left sample", int'(left_bit), int'(lcur));
                chk(pdm_bclk && !prev_bclk, "R4 strobe at rise", int'(pdm_bclk), 1);
                dens_bit(0, lcur);
            end
            if (right_valid) begin
                chk(right_bit == rcur, "R5 right sample", int'(right_bit), int'(rcur));
                chk(!pdm_bclk && prev_bclk, "R5 strobe at fall", int'(pdm_bclk), 0);
                dens_bit(1, rcur);
            end
            if (pdm_bclk && !prev_bclk) rise_t = cyc;
            if (!pdm_bclk && prev_bclk) begin
                last_hi  = cyc - rise_t;
                last_per = cyc - fall_t;
                if (mon_en) begin
                    chk(last_hi == exp_ratio / 2, "R2 high phase", last_hi, exp_ratio / 2);
                    if (have_prev) chk(last_per == exp_ratio, "R2 period", last_per, exp_ratio);
                end
                have_prev = 1'b1;
                fall_t    = cyc;
                fall_count++;
            end
            prev_bclk = pdm_bclk;
        end
    end

    task automatic wait_falls(input int n);
        int target;
        target = fall_count + n;
        while (fall_count < target) @(negedge clk);
        #2;
    endtask

    task automatic drive_ratio(input int r);
        @(posedge clk); #1;
        div_ratio = DIV_W'(r);
    endtask

    // R2/R9 sweep: change ratio, skip the transition, then check several periods.
    task automatic use_ratio(input int r);
        mon_en = 1'b0;
        drive_ratio(r);
        wait_falls(2);
        exp_ratio = (r < 4) ? 4 : r;
        mon_en    = 1'b1;
        wait_falls(4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(!pdm_bclk && !left_valid && !right_valid, "R1 reset outputs", int'(pdm_bclk), 0);
        chk(left_level == '0 && right_level == '0, "R1 reset levels", int'(left_level), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!pdm_bclk && !left_valid && !right_valid && !left_level_valid && !right_level_valid,
            "R1 idle after reset", int'(pdm_bclk), 0);

        mon_on   = 1'b1;
        win_log2 = KW'(3);
        @(posedge clk); #1;
        bclk_run = 1'b1;
        wait_falls(2);
        mon_en = 1'b1;
        wait_falls(4);

        // R2 and R9 sweep over ratios 0..11
        for (int r = 0; r < 12; r++) use_ratio(r);

        // R3: ratio changed mid-period takes effect at the next fall
        use_ratio(6);
        wait_falls(1);
        repeat (2) @(posedge clk);
        #1 div_ratio = DIV_W'(9);
        wait_falls(1);
        chk(last_per == 6, "R3 old period kept", last_per, 6);
        exp_ratio = 9;
        wait_falls(1);
        chk(last_per == 9 && last_hi == 4, "R3 new period", last_per, 9);

        // R6: stop during high phase, full high kept, then silence, then restart
        use_ratio(8);
        do begin
            @(posedge clk); #1;
        end while (!pdm_bclk);
        bclk_run = 1'b0;
        wait_falls(1);
        chk(last_hi == 4, "R6 high phase completed", last_hi, 4);
        mon_en = 1'b0;
        begin
            int noisy;
            noisy = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (pdm_bclk || left_valid || right_valid) noisy++;
            end
            chk(noisy == 0, "R6 quiet while stopped", noisy, 0);
        end
        @(posedge clk); #1;
        bclk_run = 1'b1;
        begin
            int cnt;
            cnt = 0;
            do begin
                @(negedge clk);
                cnt++;
            end while (!pdm_bclk && cnt < 50);
            chk(cnt == 6, "R6 first rise after restart", cnt, 6);
        end
        wait_falls(2);
        mon_en = 1'b1;

        // R7/R8: level windows over several patterns and window sizes
        use_ratio(4);
        for (int m = 0; m < 4; m++) begin
            for (int ki = 0; ki < 4; ki++) begin
                @(posedge clk); #1;
                mode     = m;
                win_log2 = KW'((ki == 0) ? 0 : (ki == 1) ? 2 : (ki == 2) ? 4 : 7);
                wait_falls(70);
            end
        end
        // R8: change window size in the middle of an open window
        @(posedge clk); #1;
        win_log2 = KW'(5);
        wait_falls(10);
        @(posedge clk); #1;
        win_log2 = KW'(1);
        wait_falls(60);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule